// File: doc/BRIEF.md
# UART Automatic Modem Flow Control

This block handles hardware handshaking for one UART channel. It sits between the receive FIFO, the transmit character sequencer and the two modem pins. On the receive side it watches the FIFO fill count and drives the active-low request-to-send output. RTS# drops away once the FIFO is nearly full and comes back only after the FIFO has been drained well below that point. On the transmit side it synchronises the active-low clear-to-send input. It withholds the start permit for the next character while the far end is not ready. A character that has already started always runs to the end of its stop bit.

The block also raises two interrupt status bits. The receive-data-ready bit is raised while the FIFO count is at or above a programmable trigger level, and reception keeps going past that level. The CTS-change bit is latched when the far end takes CTS# high while automatic CTS is on. Its enable can only be written while a feature-unlock input is high.

There are two state machines. `flow_rts_ctl` has two states. RTS_OFF is the reset state, with the pin high. RTS_ON drives the pin low. RTS_ON moves to RTS_OFF when the level reaches the upper threshold. RTS_OFF moves to RTS_ON when the level falls to the effective lower threshold. With automatic RTS off, the software bit picks the state. `flow_tx_gate` also has two states. TX_IDLE is between characters. TX_SEND means a character is on the line. TX_IDLE moves to TX_SEND when a pending character is granted the permit. TX_SEND moves back to TX_IDLE on the stop-bit-done strobe.

Top module: `uart_autoflow`

## Requirements
- R1: After reset `rts_n` is 1, `rx_rdy_irq` and `cts_chg_irq` are 0, and with `auto_cts_en`=0 `tx_start_ok` is 1.
- R2: With `auto_rts_en`=1, `rts_n` goes to 1 on the first clock edge at which `rx_level` >= `rts_hi_thr`.
- R3: With `auto_rts_en`=1, once `rts_n` is 1 it returns to 0 only on an edge where `rx_level` <= the effective lower threshold; levels between the two thresholds leave it unchanged.
- R4: The effective lower threshold is `rts_lo_thr` when it is below `rts_hi_thr`, otherwise `rts_hi_thr`-1. With `rts_hi_thr`=0, `rts_n` stays 1 under automatic RTS.
- R5: With `auto_rts_en`=0, `rts_n` becomes the inverse of `sw_rts` one clock edge later.
- R6: `cts_n` passes through a two-stage synchroniser. With `auto_cts_en`=1, between characters, `tx_start_ok` is 0 from the second edge after `cts_n` goes to 1. It is 1 again from the second edge after `cts_n` returns to 0.
- R7: With `auto_cts_en`=1, an edge with `char_pend`=1 and `tx_start_ok`=1 starts a character. `tx_start_ok` then stays 0, whatever `cts_n` does, until the edge that samples `stop_done`=1. After that edge the permit again follows the synchronised CTS#.
- R8: With `auto_cts_en`=0, `tx_start_ok` is 1 at all times, during a character and with `cts_n` high.
- R9: `rx_rdy_irq` is 1 one edge after `rx_level` >= `rx_trig_lvl` and 0 one edge after it falls below, while `rx_level` keeps changing.
- R10: A write through `cts_ie_wr` changes the CTS interrupt enable only when `feat_unlock`=1; a locked write leaves CTS# rises unreported.
- R11: With `auto_cts_en`=1 and the enable set, `cts_chg_irq` is 1 from the third edge after `cts_n` rises. With `auto_cts_en`=0 it stays 0.
- R12: `isr_rd` clears `cts_chg_irq` at the next edge; a new rise in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rts_hi_thr | input | LVL_W | Level at which RTS# is released |
| rts_lo_thr | input | LVL_W | Level at which RTS# is driven again |
| rx_trig_lvl | input | LVL_W | Data-ready interrupt trigger level |
| auto_rts_en | input | 1 | Automatic RTS enable |
| auto_cts_en | input | 1 | Automatic CTS enable |
| sw_rts | input | 1 | Software RTS request (1 drives pin low) when automatic RTS is off |
| feat_unlock | input | 1 | Permits writes to the CTS interrupt enable |
| cts_ie_wr | input | 1 | Write strobe for the CTS interrupt enable |
| cts_ie_wdata | input | 1 | Value written to the CTS interrupt enable |
| isr_rd | input | 1 | Interrupt status read strobe, clears the CTS bit |
| char_pend | input | 1 | Sequencer has a character waiting |
| stop_done | input | 1 | Stop bit of the current character has left the line |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_start_ok | output | 1 | Permit for the sequencer to begin a character |
| rx_rdy_irq | output | 1 | Receive data ready status |
| cts_chg_irq | output | 1 | CTS de-assertion status |

## Verification
Every fault in the RTS machine shows on `rts_n` at the first edge after the level crosses the wrong threshold, so the bench walks fill levels across both thresholds, including inverted and zero settings. If the transmit machine is stuck in TX_SEND, or misses its way into it, `tx_start_ok` is wrong one edge after the `char_pend` or `stop_done` strobe. A synchroniser of the wrong depth moves the permit edge off the second cycle. The interrupt bits are checked at the exact edge they should change, so a missing edge-detect flop or a wrong clear priority shows within three cycles.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

    typedef enum logic {
        RTS_OFF = 1'b0,
        RTS_ON  = 1'b1
    } rts_state_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] shreg;

    // Resets to the inactive (high) level so no edge is seen out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-2:0], din};
    end

    assign dout = shreg[STAGES-1];
endmodule

// File: rtl/flow_rts_ctl.sv
module flow_rts_ctl
    import uart_flow_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_assert,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] hi_thr,
    input  logic [LVL_W-1:0] lo_thr,
    output logic             rts_n
);
    rts_state_e       state, nxt;
    logic [LVL_W-1:0] eff_lo;

    always_comb begin
        if (hi_thr == '0)          eff_lo = '0;
        else if (hi_thr <= lo_thr) eff_lo = hi_thr - 1'b1;
        else                       eff_lo = lo_thr;
    end

    always_comb begin
        nxt = state;
        if (!auto_en) begin
            nxt = sw_assert ? RTS_ON : RTS_OFF;
        end else begin
            unique case (state)
                RTS_ON:  if (level >= hi_thr) nxt = RTS_OFF;
                RTS_OFF: if ((level <= eff_lo) && (level < hi_thr)) nxt = RTS_ON;
                default: nxt = RTS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RTS_OFF;
        else        state <= nxt;
    end

    always_comb begin
        rts_n = (state == RTS_OFF);
    end

    // R2
    rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) && $past(auto_en) |-> $past(level) >= $past(hi_thr));

    // R3
    rts_hyst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts_n) && $past(auto_en) |-> $past(level) <= $past(eff_lo));
endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate
    import uart_flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_hi,
    input  logic char_pend,
    input  logic stop_done,
    output logic tx_ok
);
    tx_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (char_pend && tx_ok) nxt = TX_SEND;
            TX_SEND: if (stop_done)          nxt = TX_IDLE;
            default: nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        tx_ok = !auto_en || ((state == TX_IDLE) && !cts_hi);
    end

    // R7
    no_midchar_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en && $past(char_pend && tx_ok && !stop_done) |-> !tx_ok);
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
    import uart_flow_pkg::*;
#(
    parameter int LVL_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rts_hi_thr,
    input  logic [LVL_W-1:0] rts_lo_thr,
    input  logic [LVL_W-1:0] rx_trig_lvl,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             sw_rts,
    input  logic             feat_unlock,
    input  logic             cts_ie_wr,
    input  logic             cts_ie_wdata,
    input  logic             isr_rd,
    input  logic             char_pend,
    input  logic             stop_done,
    input  logic             cts_n,
    output logic             rts_n,
    output logic             tx_start_ok,
    output logic             rx_rdy_irq,
    output logic             cts_chg_irq
);
    logic cts_s, cts_s_d, cts_ie, cts_rise, cts_set;

    flow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cts_n),
        .dout  (cts_s)
    );

    flow_rts_ctl #(.LVL_W(LVL_W)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_rts_en),
        .sw_assert (sw_rts),
        .level     (rx_level),
        .hi_thr    (rts_hi_thr),
        .lo_thr    (rts_lo_thr),
        .rts_n     (rts_n)
    );

    flow_tx_gate u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_cts_en),
        .cts_hi    (cts_s),
        .char_pend (char_pend),
        .stop_done (stop_done),
        .tx_ok     (tx_start_ok)
    );

    assign cts_rise = cts_s && !cts_s_d;
    assign cts_set  = auto_cts_en && cts_ie && cts_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts_s_d     <= 1'b1;
            cts_ie      <= 1'b0;
            rx_rdy_irq  <= 1'b0;
            cts_chg_irq <= 1'b0;
        end else begin
            cts_s_d    <= cts_s;
            rx_rdy_irq <= (rx_level >= rx_trig_lvl);
            if (cts_ie_wr && feat_unlock) cts_ie <= cts_ie_wdata;
            if (cts_set)     cts_chg_irq <= 1'b1;
            else if (isr_rd) cts_chg_irq <= 1'b0;
        end
    end

    // R6
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_cts_en && $past(cts_n, 2) |-> !tx_start_ok);

    // R10
    ie_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cts_ie_wr && !feat_unlock |=> $stable(cts_ie));

    // R11
    cts_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cts_chg_irq) |-> $past(auto_cts_en && cts_ie));

    // R12
    isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_rd && !cts_set |=> !cts_chg_irq);
endmodule

// File: tb/sim_uart_autoflow.sv
`timescale 1ns/1ps
module sim_uart_autoflow;
    localparam int W = 8;
    localparam int NV = 14;

    logic clk = 1'b0;
    logic rst_n;
    logic [W-1:0] rx_level, rts_hi_thr, rts_lo_thr, rx_trig_lvl;
    logic auto_rts_en, auto_cts_en, sw_rts, feat_unlock, cts_ie_wr, cts_ie_wdata;
    logic isr_rd, char_pend, stop_done, cts_n;
    logic rts_n, tx_start_ok, rx_rdy_irq, cts_chg_irq;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_autoflow #(.LVL_W(W), .SYNC_STAGES(2)) u0 (.*);

    // {auto_rts, sw_rts, level, hi, lo, exp_rts_n, exp_rdy}; trigger fixed at 8
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'd0,  8'd12, 8'd4, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'd11, 8'd12, 8'd4, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'd12, 8'd12, 8'd4, 1'b1, 1'b1},
        {1'b1, 1'b0, 8'd8,  8'd12, 8'd4, 1'b1, 1'b1},
        {1'b1, 1'b0, 8'd5,  8'd12, 8'd4, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'd4,  8'd12, 8'd4, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'd11, 8'd12, 8'd4, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'd5,  8'd5,  8'd9, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'd6,  8'd5,  8'd9, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'd4,  8'd5,  8'd9, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'd0,  8'd5,  8'd9, 1'b1, 1'b0},
        {1'b0, 1'b1, 8'd20, 8'd5,  8'd9, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'd20, 8'd5,  8'd9, 1'b1, 1'b1},
        {1'b1, 1'b0, 8'd0,  8'd0,  8'd0, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        rx_level = '0; rts_hi_thr = 8'd12; rts_lo_thr = 8'd4; rx_trig_lvl = 8'd8;
        auto_rts_en = 1'b0; auto_cts_en = 1'b0; sw_rts = 1'b0;
        feat_unlock = 1'b0; cts_ie_wr = 1'b0; cts_ie_wdata = 1'b0;
        isr_rd = 1'b0; char_pend = 1'b0; stop_done = 1'b0; cts_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 rts_n", rts_n, 1);
        check("R1 tx_start_ok", tx_start_ok, 1);
        check("R1 cts_chg_irq", cts_chg_irq, 0);

        // R2 R3 R4 R5 R9 vector walk
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            auto_rts_en = v[27]; sw_rts = v[26];
            rx_level = v[25:18]; rts_hi_thr = v[17:10]; rts_lo_thr = v[9:2];
            tick(1);
            check($sformatf("R2/R3/R4/R5 vec%0d rts_n", i), rts_n, v[1]);
            check($sformatf("R9 vec%0d rx_rdy_irq", i), rx_rdy_irq, v[0]);
        end

        // R6 synchroniser latency, between characters
        auto_cts_en = 1'b1; cts_n = 1'b0;
        tick(3);
        check("R6 permit with cts low", tx_start_ok, 1);
        cts_n = 1'b1;
        tick(1);
        check("R6 permit one edge after cts high", tx_start_ok, 1);
        tick(1);
        check("R6 hold two edges after cts high", tx_start_ok, 0);
        cts_n = 1'b0;
        tick(1);
        check("R6 still held one edge after cts low", tx_start_ok, 0);
        tick(1);
        check("R6 resume two edges after cts low", tx_start_ok, 1);

        // R7 character in flight
        char_pend = 1'b1;
        tick(1);
        char_pend = 1'b0;
        check("R7 permit drops at start", tx_start_ok, 0);
        cts_n = 1'b1;
        tick(3);
        check("R7 no change mid-character", tx_start_ok, 0);
        stop_done = 1'b1;
        tick(1);
        stop_done = 1'b0;
        check("R7 held after stop with cts high", tx_start_ok, 0);
        cts_n = 1'b0;
        tick(2);
        check("R7 resume after cts low", tx_start_ok, 1);
        char_pend = 1'b1;
        tick(1);
        char_pend = 1'b0;
        stop_done = 1'b1;
        tick(1);
        stop_done = 1'b0;
        check("R7 permit right after stop with cts low", tx_start_ok, 1);

        // R8 auto CTS off
        auto_cts_en = 1'b0; cts_n = 1'b1; char_pend = 1'b1;
        tick(3);
        char_pend = 1'b0;
        check("R8 permit with cts high, auto off", tx_start_ok, 1);
        cts_n = 1'b0;
        tick(3);

        // R10 locked write
        auto_cts_en = 1'b1;
        cts_ie_wr = 1'b1; cts_ie_wdata = 1'b1; feat_unlock = 1'b0;
        tick(1);
        cts_ie_wr = 1'b0;
        cts_n = 1'b1;
        tick(3);
        check("R10 locked enable leaves rise unreported", cts_chg_irq, 0);
        cts_n = 1'b0;
        tick(3);
        feat_unlock = 1'b1; cts_ie_wr = 1'b1;
        tick(1);
        cts_ie_wr = 1'b0; feat_unlock = 1'b0;

        // R11 rise reported on third edge
        cts_n = 1'b1;
        tick(2);
        check("R11 not yet set at second edge", cts_chg_irq, 0);
        tick(1);
        check("R11 set at third edge", cts_chg_irq, 1);

        // R12 read clears
        isr_rd = 1'b1;
        tick(1);
        isr_rd = 1'b0;
        check("R12 cleared by read", cts_chg_irq, 0);

        // R11 auto CTS off: no report
        cts_n = 1'b0; auto_cts_en = 1'b0;
        tick(3);
        cts_n = 1'b1;
        tick(4);
        check("R11 no report with auto CTS off", cts_chg_irq, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule